// File: doc/BRIEF.md
# DS3 Transmit Overhead Insertion Port

This block sits on the serial transmit path of a DS3 framer. It receives one line bit per clock, and that stream already holds the internally generated overhead and the payload. It returns the same stream one clock later. Along the way, any overhead bit can be taken from an external device. The block keeps its own M-frame timing of 4760 bits: 7 subframes, each of 8 blocks of 85 bits, and each block begins with one overhead bit. It uses this timing to signal the external device over a side port.

In the line bit just before each overhead bit, the block raises an overhead strobe. On the last strobe of a frame it also raises a frame marker, which announces the first overhead bit (X1) of the next frame. At the end of the strobe cycle the block samples the external enable and data bits. If the enable is high, the external bit is used for the overhead bit that follows. At the two parity slots the external bit is XOR-ed into the internal parity as an error mask. At every other slot it replaces the internal bit. Payload bits always pass through unchanged.

Control is a three-state machine over the 85-bit block:
- PH_STROBE is the last bit of a block. It drives the strobe and moves to PH_OH.
- PH_OH is the overhead bit. It applies the sampled decision and moves to PH_PAY.
- PH_PAY covers the payload bits 1 to 83. It counts them and moves to PH_STROBE after bit 83.

Reset enters PH_STROBE on the last slot of a frame, so the first bit after reset is X1.

Top module: `ds3_oh_insert`

## Requirements
- R1: While reset is held, tx_out is 0 and both oh_clk and oh_sof are 1. In the first line bit after reset, both strobes are still 1.
- R2: oh_clk is high for exactly one line bit in every 85, the bit before each overhead bit. It is never high on two bits in a row.
- R3: oh_sof is high only together with oh_clk, once every 4760 line bits. It marks the strobe that precedes slot 0 (X1) of a frame.
- R4: tx_out equals the tx_in of the previous clock at every payload position, whatever ext_en and ext_dat hold.
- R5: If ext_en was 0 at the preceding strobe, an overhead bit leaves unchanged, one clock later.
- R6: If ext_en was 1 at the preceding strobe and the slot is not a parity slot, the overhead bit leaves as the ext_dat captured at that strobe. Slots are numbered s = 8*subframe + k, with subframe 0..6 and k 0..7 in the order X/P/M, F1, C1, F2, C2, F3, C3, F4.
- R7: The parity slots are s = 16 (P1) and s = 24 (P2). At these slots, with ext_en captured as 1, the overhead bit leaves as tx_in XOR the captured ext_dat.
- R8: ext_en and ext_dat are sampled only at the end of a strobe cycle. Their values in any other cycle have no effect on tx_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_in | input | 1 | Transmit stream with internal overhead and parity |
| ext_en | input | 1 | External insertion enable, sampled at strobe |
| ext_dat | input | 1 | External overhead bit or parity error mask |
| oh_clk | output | 1 | Overhead strobe, one bit before each overhead bit |
| oh_sof | output | 1 | Frame marker, strobe preceding X1 |
| tx_out | output | 1 | Transmit stream after insertion, one clock delay |

## Verification
The assertions assume that tx_in, ext_en and ext_dat are known and stable around each rising clock edge. They also assume reset is held for at least one edge. The bench changes every input only at the falling edge and keeps reset asserted for several clocks. Inside those limits the bench drives ext_en and ext_dat with random values on every cycle, not only on strobe cycles, so the sample window is exercised. It runs one frame with the enable held low, one with it held high, and three with random enables, and each overhead slot is checked against a model of the frame position.

// File: rtl/ds3oh_pkg.sv
package ds3oh_pkg;

    localparam int unsigned BLOCK_BITS_DEF   = 85;
    localparam int unsigned SUBFRAMES_DEF    = 7;
    localparam int unsigned SLOTS_PER_SF_DEF = 8;
    localparam int unsigned PAR1_SF          = 2;
    localparam int unsigned PAR2_SF          = 3;

    typedef enum logic [1:0] {
        PH_PAY    = 2'd0,
        PH_STROBE = 2'd1,
        PH_OH     = 2'd2
    } phase_e;

    function automatic logic is_parity_slot(input int unsigned sf, input int unsigned k);
        return (k == 0) && ((sf == PAR1_SF) || (sf == PAR2_SF));
    endfunction

endpackage

// File: rtl/ds3oh_timing.sv
module ds3oh_timing
    import ds3oh_pkg::*;
#(
    parameter int unsigned BLOCK_BITS   = BLOCK_BITS_DEF,
    parameter int unsigned SUBFRAMES    = SUBFRAMES_DEF,
    parameter int unsigned SLOTS_PER_SF = SLOTS_PER_SF_DEF
) (
    input  logic clk,
    input  logic rst_n,
    output logic strobe,
    output logic sof,
    output logic is_oh,
    output logic is_p
);
    localparam int unsigned BW  = $clog2(BLOCK_BITS);
    localparam int unsigned SFW = $clog2(SUBFRAMES);
    localparam int unsigned KW  = $clog2(SLOTS_PER_SF);
    localparam logic [BW-1:0]  BIT_LAST = BW'(BLOCK_BITS - 1);
    localparam logic [BW-1:0]  BIT_PRE  = BW'(BLOCK_BITS - 2);
    localparam logic [SFW-1:0] SF_LAST  = SFW'(SUBFRAMES - 1);
    localparam logic [KW-1:0]  K_LAST   = KW'(SLOTS_PER_SF - 1);

    phase_e         state, nstate;
    logic [BW-1:0]  bit_cnt, nbit;
    logic [SFW-1:0] sf_cnt, nsf;
    logic [KW-1:0]  k_cnt, nk;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= PH_STROBE;
            bit_cnt <= BIT_LAST;
            sf_cnt  <= SF_LAST;
            k_cnt   <= K_LAST;
        end else begin
            state   <= nstate;
            bit_cnt <= nbit;
            sf_cnt  <= nsf;
            k_cnt   <= nk;
        end
    end

    always_comb begin
        nstate = state;
        nbit   = bit_cnt;
        nsf    = sf_cnt;
        nk     = k_cnt;
        unique case (state)
            PH_STROBE: begin
                nstate = PH_OH;
                nbit   = '0;
                if (k_cnt == K_LAST) begin
                    nk  = '0;
                    nsf = (sf_cnt == SF_LAST) ? '0 : sf_cnt + 1'b1;
                end else begin
                    nk  = k_cnt + 1'b1;
                end
            end
            PH_OH: begin
                nstate = PH_PAY;
                nbit   = BW'(1);
            end
            PH_PAY: begin
                nbit = bit_cnt + 1'b1;
                if (bit_cnt == BIT_PRE) nstate = PH_STROBE;
            end
            default: nstate = PH_STROBE;
        endcase
    end

    always_comb begin
        strobe = (state == PH_STROBE);
        sof    = strobe && (k_cnt == K_LAST) && (sf_cnt == SF_LAST);
        is_oh  = (state == PH_OH);
        is_p   = is_oh && is_parity_slot(int'(sf_cnt), int'(k_cnt));
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe); // R2
    AST_SOF_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> strobe); // R3
    AST_OH_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        is_oh |-> $past(strobe)); // R2

endmodule

// File: rtl/ds3oh_capture.sv
module ds3oh_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic ext_en,
    input  logic ext_dat,
    output logic en_q,
    output logic dat_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            dat_q <= 1'b0;
        end else if (strobe) begin
            en_q  <= ext_en;
            dat_q <= ext_dat;
        end
    end

    AST_HOLD_OFF_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> ($stable(en_q) && $stable(dat_q))); // R8
    AST_TAKE_AT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (en_q == $past(ext_en))); // R8

endmodule

// File: rtl/ds3oh_merge.sv
module ds3oh_merge (
    input  logic clk,
    input  logic rst_n,
    input  logic in_bit,
    input  logic is_oh,
    input  logic is_p,
    input  logic en_q,
    input  logic dat_q,
    output logic out_bit
);
    logic mixed;

    always_comb begin
        mixed = in_bit;
        if (is_oh && en_q) mixed = is_p ? (in_bit ^ dat_q) : dat_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_bit <= 1'b0;
        else        out_bit <= mixed;
    end

endmodule

// File: rtl/ds3_oh_insert.sv
module ds3_oh_insert
    import ds3oh_pkg::*;
#(
    parameter int unsigned BLOCK_BITS   = BLOCK_BITS_DEF,
    parameter int unsigned SUBFRAMES    = SUBFRAMES_DEF,
    parameter int unsigned SLOTS_PER_SF = SLOTS_PER_SF_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_in,
    input  logic ext_en,
    input  logic ext_dat,
    output logic oh_clk,
    output logic oh_sof,
    output logic tx_out
);
    logic is_oh, is_p, en_q, dat_q;

    ds3oh_timing #(
        .BLOCK_BITS  (BLOCK_BITS),
        .SUBFRAMES   (SUBFRAMES),
        .SLOTS_PER_SF(SLOTS_PER_SF)
    ) u_timing (
        .clk   (clk),
        .rst_n (rst_n),
        .strobe(oh_clk),
        .sof   (oh_sof),
        .is_oh (is_oh),
        .is_p  (is_p)
    );

    ds3oh_capture u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (oh_clk),
        .ext_en (ext_en),
        .ext_dat(ext_dat),
        .en_q   (en_q),
        .dat_q  (dat_q)
    );

    ds3oh_merge u_merge (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_bit (tx_in),
        .is_oh  (is_oh),
        .is_p   (is_p),
        .en_q   (en_q),
        .dat_q  (dat_q),
        .out_bit(tx_out)
    );

    AST_PAYLOAD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !is_oh |=> (tx_out == $past(tx_in))); // R4
    AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_oh && !en_q) |=> (tx_out == $past(tx_in))); // R5
    AST_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_oh && en_q && !is_p) |=> (tx_out == $past(dat_q))); // R6
    AST_PARITY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (is_oh && en_q && is_p) |=> (tx_out == ($past(tx_in) ^ $past(dat_q)))); // R7

endmodule

// File: tb/sim_ds3_oh_insert.sv
module sim_ds3_oh_insert;
    localparam int BB = 85;
    localparam int FR = 4760;
    localparam int NCYC = 5 * FR + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_in = 1'b0, ext_en = 1'b0, ext_dat = 1'b0;
    logic oh_clk, oh_sof, tx_out;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ds3_oh_insert u0 (
        .clk(clk), .rst_n(rst_n), .tx_in(tx_in), .ext_en(ext_en),
        .ext_dat(ext_dat), .oh_clk(oh_clk), .oh_sof(oh_sof), .tx_out(tx_out)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit parity_slot(input int slot);
        return (slot % 8 == 0) && ((slot / 8 == 2) || (slot / 8 == 3));
    endfunction

    initial begin
        #(10 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic cap_en, cap_dat, exp_q;
        string tag_q;
        int seed;
        seed = $urandom(32'd2024);
        cap_en = 0; cap_dat = 0; exp_q = 0; tag_q = "R4";
        repeat (4) @(negedge clk);
        chk("R1 tx_out", tx_out, 1'b0);
        chk("R1 oh_clk", oh_clk, 1'b1);
        chk("R1 oh_sof", oh_sof, 1'b1);
        rst_n = 1'b1;
        for (int c = 0; c < NCYC; c++) begin
            int g, bp, slot, frm;
            logic exp_clk, exp_sof;
            g = (c + FR - 1) % FR;
            bp = g % BB;
            slot = g / BB;
            frm = c / FR;
            exp_clk = (bp == BB - 1);
            exp_sof = exp_clk && (slot == FR / BB - 1);
            if (c == 0) begin
                chk("R1 first oh_clk", oh_clk, 1'b1);
                chk("R1 first oh_sof", oh_sof, 1'b1);
            end else begin
                chk("R2 oh_clk", oh_clk, exp_clk);
                chk("R3 oh_sof", oh_sof, exp_sof);
                chk(tag_q, tx_out, exp_q);
            end
            tx_in   = 1'($urandom);
            ext_en  = 1'($urandom);
            ext_dat = 1'($urandom);
            if (exp_clk) begin
                if (frm == 0)      ext_en = 1'b0;
                else if (frm == 1) ext_en = 1'b1;
                if (c == NCYC - 2) begin
                    ext_en = 1'b1;
                    ext_dat = 1'b1;
                end
            end
            if (bp == 0) begin
                if (!cap_en) begin
                    exp_q = tx_in; tag_q = "R5 R8 pass";
                end else if (parity_slot(slot)) begin
                    exp_q = tx_in ^ cap_dat; tag_q = "R7 R8 parity";
                end else begin
                    exp_q = cap_dat; tag_q = "R6 R8 replace";
                end
            end else begin
                exp_q = tx_in; tag_q = "R4 R8 payload";
            end
            if (exp_clk) begin
                cap_en = ext_en;
                cap_dat = ext_dat;
            end
            @(negedge clk);
        end
        chk(tag_q, tx_out, exp_q);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule